// File: doc/BRIEF.md
# Gain and Skew Correction Engine

This block sits on the data path of one sub-converter in a two-way time-interleaved ADC. It takes a background estimate of that channel's gain and sampling-time mismatch and corrects the channel so that it lines up with the reference channel. Each accepted sample is first multiplied by a gain word. It then passes through a four-tap fractional-delay filter. The filter's taps vary linearly with a signed delay word, which makes it a first-order Farrow structure around a symmetric half-sample base filter. The filter is folded so that the constant part uses sums of mirrored taps and the delay-dependent part uses differences of mirrored taps. The only run-time multiplication is the one by the delay word.

The block runs at the sub-converter rate, with one sample per `in_valid` pulse, and idle cycles are allowed between samples. The reference channel's sample travels through a matching delay line and leaves on the same cycle as the corrected sample, so the two streams can be re-interleaved without reordering.

A small controller has two states. `PRIME` fills the tap line after reset. `STREAM` is entered from `PRIME` when the fourth sample enters the tap line, and it is left only by reset. The two transitions are fill-complete (`PRIME` to `STREAM`) and reset (any state to `PRIME`).

Top module: `mismatch_corrector`

## Requirements
- R1: While reset is asserted and after reset is released, `out_valid` is 0 and both `out_ch` and `out_ref` are 0, until the first output is produced.
- R2: After reset, the first three accepted samples produce no output. Every later accepted sample produces exactly one `out_valid` pulse, and outputs leave in acceptance order. Once `STREAM` is entered it is kept until reset.
- R3: A sample accepted at a rising edge, with `in_valid` high before that edge, has its result presented after the fifth rising edge, counting the accepting edge as the first. The latency is 5 clock cycles.
- R4: Gain stage: g = sat14(floor((ch × G + 8192) / 16384)). G is the 16-bit unsigned `gain_word`, where 16384 means unity gain. ch is the signed 14-bit `ch_samp`. sat14 clamps to [-8192, 8191].
- R5: The newest gained sample is x0 and the oldest of four is x3. The output is y = sat14(floor((256·B + d·C + 2^19) / 2^20)), where B = -256(x0+x3) + 2304(x1+x2), C = 171(x0−x3) − 4608(x1−x2), and d is the `dly_word` of the newest sample.
- R6: `dly_word` is signed 8-bit two's complement in units of 1/256 sample, and a positive value adds delay. With unity gain, d = 0 and a constant input, the output equals the input.
- R7: The output is rounded half-up and clamped to 14 bits. An overshooting pattern gives exactly 8191 or −8192. A gained value above the range is clamped before the filter.
- R8: `gain_word` and `dly_word` are sampled only on cycles where `in_valid` is high, and they apply to the sample accepted on that cycle. Their values on other cycles have no effect.
- R9: `out_ref` is the `ref_samp` that was accepted one sample before the newest channel sample of the same output. It is presented on the same cycle as that output.
- R10: Cycles with `in_valid` low do not advance the tap line. Results do not depend on gaps between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new sample pair and correction words are present |
| ch_samp | input | 14 | Signed sample of the channel to correct |
| ref_samp | input | 14 | Signed sample of the reference channel |
| gain_word | input | 16 | Unsigned gain correction, 16384 = unity |
| dly_word | input | 8 | Signed fractional delay, 1/256 sample per step |
| out_valid | output | 1 | Corrected pair is present |
| out_ch | output | 14 | Corrected channel sample |
| out_ref | output | 14 | Latency-matched reference sample |

## Verification
Several properties are checked on every cycle. The shadow gain and delay registers must hold while `in_valid` is low. Tap registers must not move without a shift. A unity shadow gain must pass the captured sample through unchanged. Every `out_valid` must trace back to an accepted sample exactly five cycles earlier, and the controller must never leave `STREAM`. The arithmetic itself can only be shown by the bench's scenarios, which compare against an independent model. These cover the folded Farrow filter at several delay words and gains, saturation on overshoot, reference alignment, gap-independence and the priming count after a reset in mid-stream.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [0:0] {
        ST_PRIME  = 1'b0,
        ST_STREAM = 1'b1
    } fill_state_t;

    localparam int TAPS      = 4;
    localparam int COEF_FRAC = 12;
    localparam int COEF_W    = COEF_FRAC + 3;

    // symmetric half-sample base filter (outer, inner pair)
    localparam int K_BASE_OUT  = -((1 << COEF_FRAC) / 16);
    localparam int K_BASE_IN   = (9 << COEF_FRAC) / 16;
    // antisymmetric slope against the delay word
    localparam int K_SLOPE_OUT = ((1 << COEF_FRAC) + 12) / 24;
    localparam int K_SLOPE_IN  = -((9 << COEF_FRAC) / 8);

endpackage

// File: rtl/mc_gain_stage.sv
module mc_gain_stage #(
    parameter int SAMP_W    = 14,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int DLY_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] ch_in,
    input  logic signed [SAMP_W-1:0] ref_in,
    input  logic        [GAIN_W-1:0] gain_in,
    input  logic signed [DLY_W-1:0]  dly_in,
    output logic                     g_valid,
    output logic signed [SAMP_W-1:0] g_samp,
    output logic signed [SAMP_W-1:0] g_ref,
    output logic signed [DLY_W-1:0]  g_dly
);

    localparam int PW = SAMP_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] P_MAX  = PW'((2 ** (SAMP_W - 1)) - 1);
    localparam logic signed [PW-1:0] P_MIN  = -P_MAX - 1;
    localparam logic signed [PW-1:0] P_HALF = PW'(2 ** (GAIN_FRAC - 1));
    localparam logic [GAIN_W-1:0]    UNITY  = GAIN_W'(2 ** GAIN_FRAC);

    // shadow registers: loaded only on a sample boundary
    logic                     a_valid;
    logic signed [SAMP_W-1:0] ch_sh;
    logic signed [SAMP_W-1:0] ref_sh;
    logic        [GAIN_W-1:0] gain_sh;
    logic signed [DLY_W-1:0]  dly_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            ch_sh   <= '0;
            ref_sh  <= '0;
            gain_sh <= '0;
            dly_sh  <= '0;
        end else begin
            a_valid <= in_valid;
            if (in_valid) begin
                ch_sh   <= ch_in;
                ref_sh  <= ref_in;
                gain_sh <= gain_in;
                dly_sh  <= dly_in;
            end
        end
    end

    logic signed [PW-1:0]     prod_w;
    logic signed [PW-1:0]     rnd_w;
    logic signed [PW-1:0]     shf_w;
    logic signed [SAMP_W-1:0] sat_w;

    always_comb begin
        prod_w = ch_sh * $signed({1'b0, gain_sh});
        rnd_w  = prod_w + P_HALF;
        shf_w  = rnd_w >>> GAIN_FRAC;
        if (shf_w > P_MAX) begin
            sat_w = P_MAX[SAMP_W-1:0];
        end else if (shf_w < P_MIN) begin
            sat_w = P_MIN[SAMP_W-1:0];
        end else begin
            sat_w = shf_w[SAMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_valid <= 1'b0;
            g_samp  <= '0;
            g_ref   <= '0;
            g_dly   <= '0;
        end else begin
            g_valid <= a_valid;
            if (a_valid) begin
                g_samp <= sat_w;
                g_ref  <= ref_sh;
                g_dly  <= dly_sh;
            end
        end
    end

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(gain_sh) && $stable(dly_sh)));

    // R4
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && gain_sh == UNITY) |=> (g_samp == $past(ch_sh)));

endmodule

// File: rtl/mc_frac_delay.sv
module mc_frac_delay
    import mc_pkg::*;
#(
    parameter int SAMP_W = 14,
    parameter int DLY_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     emit_in,
    input  logic signed [SAMP_W-1:0] samp_in,
    input  logic signed [DLY_W-1:0]  dly_in,
    output logic                     y_valid,
    output logic signed [SAMP_W-1:0] y_out
);

    localparam int SW1   = SAMP_W + 1;
    localparam int PRD_W = SAMP_W + COEF_W + 2;
    localparam int ACC_W = PRD_W + DLY_W + 1;
    localparam int SHIFT = COEF_FRAC + DLY_W;

    localparam logic signed [COEF_W-1:0] KBO = COEF_W'(K_BASE_OUT);
    localparam logic signed [COEF_W-1:0] KBI = COEF_W'(K_BASE_IN);
    localparam logic signed [COEF_W-1:0] KSO = COEF_W'(K_SLOPE_OUT);
    localparam logic signed [COEF_W-1:0] KSI = COEF_W'(K_SLOPE_IN);

    localparam logic signed [ACC_W-1:0] A_MAX  = ACC_W'((2 ** (SAMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] A_MIN  = -A_MAX - 1;
    localparam logic signed [ACC_W-1:0] A_HALF = ACC_W'(1) <<< (SHIFT - 1);

    // stage C: tap line, index 0 newest
    logic signed [SAMP_W-1:0] tap_q [TAPS];
    logic signed [DLY_W-1:0]  dly_c;
    logic                     emit_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
            dly_c  <= '0;
            emit_c <= 1'b0;
        end else begin
            emit_c <= shift_en & emit_in;
            if (shift_en) begin
                tap_q[0] <= samp_in;
                for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
                dly_c <= dly_in;
            end
        end
    end

    // folded symmetric / antisymmetric pairs
    logic signed [SW1-1:0]   sum_o, sum_i, dif_o, dif_i;
    logic signed [PRD_W-1:0] base_w, slope_w;

    always_comb begin
        sum_o   = tap_q[0] + tap_q[TAPS-1];
        sum_i   = tap_q[1] + tap_q[TAPS-2];
        dif_o   = tap_q[0] - tap_q[TAPS-1];
        dif_i   = tap_q[1] - tap_q[TAPS-2];
        base_w  = KBO * sum_o + KBI * sum_i;
        slope_w = KSO * dif_o + KSI * dif_i;
    end

    // stage D
    logic signed [PRD_W-1:0] base_d, slope_d;
    logic signed [DLY_W-1:0] dly_d;
    logic                    v_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_d  <= '0;
            slope_d <= '0;
            dly_d   <= '0;
            v_d     <= 1'b0;
        end else begin
            base_d  <= base_w;
            slope_d <= slope_w;
            dly_d   <= dly_c;
            v_d     <= emit_c;
        end
    end

    // stage E: Farrow combine, round, clamp
    logic signed [ACC_W-1:0]  base_x, acc_w, rnd_w, shf_w;
    logic signed [SAMP_W-1:0] sat_w;

    always_comb begin
        base_x = base_d;
        acc_w  = (base_x <<< DLY_W) + slope_d * dly_d;
        rnd_w  = acc_w + A_HALF;
        shf_w  = rnd_w >>> SHIFT;
        if (shf_w > A_MAX) begin
            sat_w = A_MAX[SAMP_W-1:0];
        end else if (shf_w < A_MIN) begin
            sat_w = A_MIN[SAMP_W-1:0];
        end else begin
            sat_w = shf_w[SAMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_valid <= 1'b0;
            y_out   <= '0;
        end else begin
            y_valid <= v_d;
            if (v_d) y_out <= sat_w;
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_tap_chk
        // R10
        tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !shift_en |=> $stable(tap_q[g]));
    end

endmodule

// File: rtl/mc_ref_align.sv
module mc_ref_align #(
    parameter int SAMP_W = 14,
    parameter int LAG    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     emit_in,
    input  logic signed [SAMP_W-1:0] ref_in,
    output logic signed [SAMP_W-1:0] ref_out
);

    localparam int DEPTH = LAG + 1;

    logic signed [SAMP_W-1:0] line_q [DEPTH];
    logic signed [SAMP_W-1:0] ref_d;
    logic                     emit_c, v_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
            emit_c  <= 1'b0;
            v_d     <= 1'b0;
            ref_d   <= '0;
            ref_out <= '0;
        end else begin
            emit_c <= shift_en & emit_in;
            if (shift_en) begin
                line_q[0] <= ref_in;
                for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
            end
            ref_d <= line_q[LAG];
            v_d   <= emit_c;
            if (v_d) ref_out <= ref_d;
        end
    end

endmodule

// File: rtl/mismatch_corrector.sv
module mismatch_corrector
    import mc_pkg::*;
#(
    parameter int SAMP_W    = 14,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int DLY_W     = 8,
    parameter int REF_LAG   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] ch_samp,
    input  logic signed [SAMP_W-1:0] ref_samp,
    input  logic        [GAIN_W-1:0] gain_word,
    input  logic signed [DLY_W-1:0]  dly_word,
    output logic                     out_valid,
    output logic signed [SAMP_W-1:0] out_ch,
    output logic signed [SAMP_W-1:0] out_ref
);

    localparam int CNT_W = $clog2(TAPS);

    logic                     g_valid;
    logic signed [SAMP_W-1:0] g_samp, g_ref;
    logic signed [DLY_W-1:0]  g_dly;

    mc_gain_stage #(
        .SAMP_W(SAMP_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .DLY_W(DLY_W)
    ) u_gain (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ch_in(ch_samp), .ref_in(ref_samp), .gain_in(gain_word), .dly_in(dly_word),
        .g_valid(g_valid), .g_samp(g_samp), .g_ref(g_ref), .g_dly(g_dly)
    );

    // fill controller
    fill_state_t      state_q, state_n;
    logic [CNT_W-1:0] fill_q;
    logic             emit;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_PRIME:  if (g_valid && fill_q == CNT_W'(TAPS - 1)) state_n = ST_STREAM;
            ST_STREAM: state_n = ST_STREAM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            fill_q  <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_PRIME && g_valid && fill_q != CNT_W'(TAPS - 1))
                fill_q <= fill_q + 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PRIME:  emit = (fill_q == CNT_W'(TAPS - 1));
            ST_STREAM: emit = 1'b1;
        endcase
    end

    mc_frac_delay #(
        .SAMP_W(SAMP_W), .DLY_W(DLY_W)
    ) u_fir (
        .clk(clk), .rst_n(rst_n), .shift_en(g_valid), .emit_in(emit),
        .samp_in(g_samp), .dly_in(g_dly),
        .y_valid(out_valid), .y_out(out_ch)
    );

    mc_ref_align #(
        .SAMP_W(SAMP_W), .LAG(REF_LAG)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .shift_en(g_valid), .emit_in(emit),
        .ref_in(g_ref), .ref_out(out_ref)
    );

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 5));

    // R2
    stream_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STREAM |=> state_q == ST_STREAM);

    // R2
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> state_q == ST_STREAM);

endmodule

// File: tb/tb_mismatch_corrector.sv
`timescale 1ns/1ps
module tb_mismatch_corrector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [13:0] ch_samp = '0;
    logic signed [13:0] ref_samp = '0;
    logic [15:0] gain_word = '0;
    logic signed [7:0] dly_word = '0;
    logic out_valid;
    logic signed [13:0] out_ch, out_ref;

    always #2 clk = ~clk;

    mismatch_corrector dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ch_samp(ch_samp), .ref_samp(ref_samp), .gain_word(gain_word), .dly_word(dly_word),
        .out_valid(out_valid), .out_ch(out_ch), .out_ref(out_ref)
    );

    // stimulus table: channel sample, gain, delay, idle cycles after
    localparam int NV = 16;
    localparam int T_CH   [NV] = '{1200, -3400, 5000, 800, -7000, 6100, -2500, 300,
                                   4095, -4096, 7800, -8000, 150, -60, 2222, -1111};
    localparam int T_GAIN [NV] = '{16384, 16384, 18000, 15000, 16384, 20000, 12000, 16384,
                                   17000, 16000, 16384, 16384, 19000, 14000, 16384, 16384};
    localparam int T_DLY  [NV] = '{0, 0, 64, -64, 127, -128, 0, 30,
                                   -30, 100, -100, 5, 0, 77, -77, 0};
    localparam int T_GAP  [NV] = '{0, 1, 0, 2, 0, 0, 1, 0, 3, 0, 0, 1, 0, 0, 2, 0};

    int total = 0, bad = 0;
    int sent_n = 0, out_n = 0;
    bit done = 0;
    string cur_req = "R5";
    int s_ch [256], s_ref [256], s_gain [256], s_dly [256];

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat14(longint v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return int'(v);
    endfunction

    function automatic int gained(int n);
        return sat14((longint'(s_ch[n]) * s_gain[n] + 8192) >>> 14);
    endfunction

    function automatic int exp_out(int n);
        longint x0, x1, x2, x3, bs, cs, acc;
        x0 = gained(n); x1 = gained(n-1); x2 = gained(n-2); x3 = gained(n-3);
        bs = -256 * (x0 + x3) + 2304 * (x1 + x2);
        cs = 171 * (x0 - x3) - 4608 * (x1 - x2);
        acc = bs * 256 + cs * s_dly[n];
        return sat14((acc + 524288) >>> 20);
    endfunction

    // called at a falling edge; returns at a falling edge
    task automatic send(int ch, int rf, int g, int d, int gap);
        in_valid  = 1'b1;
        ch_samp   = 14'(ch);
        ref_samp  = 14'(rf);
        gain_word = 16'(g);
        dly_word  = 8'(d);
        s_ch[sent_n] = ch; s_ref[sent_n] = rf; s_gain[sent_n] = g; s_dly[sent_n] = d;
        sent_n++;
        @(negedge clk);
        in_valid  = 1'b0;
        ch_samp   = ~ch_samp;
        gain_word = ~gain_word;   // junk between samples (R8)
        dly_word  = ~dly_word;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1 during reset
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "out_ch in reset", int'(out_ch), 0);
        chk("R1", "out_ref in reset", int'(out_ref), 0);
        sent_n = 0; out_n = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // output monitor against the independent model
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int n;
            n = out_n + 3;
            chk(cur_req, $sformatf("out_ch #%0d", n), int'(out_ch), exp_out(n));
            chk("R9", $sformatf("out_ref #%0d", n), int'(out_ref), s_ref[n-1]);
            out_n++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL all watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 after release, before any sample
        repeat (3) @(negedge clk);
        chk("R1", "out_valid idle", int'(out_valid), 0);
        chk("R1", "out_ch idle", int'(out_ch), 0);

        // R2 priming: three samples, no output
        cur_req = "R5";
        for (int i = 0; i < 3; i++) send(500 * i - 400, 11 * i, 16384, 0, 1);
        repeat (8) @(negedge clk);
        chk("R2", "outputs after three samples", out_n, 0);

        // table walk back-to-back (R5)
        for (int i = 0; i < NV; i++) send(T_CH[i], 100 * i - 700, T_GAIN[i], T_DLY[i], 0);
        repeat (8) @(negedge clk);
        chk("R2", "output count", out_n, sent_n - 3);

        // same table with idle gaps (R10), after a reset mid-activity
        do_reset();
        cur_req = "R10";
        for (int i = 0; i < NV; i++) send(T_CH[i], 100 * i - 700, T_GAIN[i], T_DLY[i], T_GAP[i]);
        repeat (8) @(negedge clk);
        chk("R2", "gapped output count", out_n, sent_n - 3);

        // R4: constant input, gain 1.5
        cur_req = "R4";
        for (int i = 0; i < 5; i++) send(3000, i, 24576, 0, 0);
        repeat (8) @(negedge clk);
        chk("R4", "gain 1.5 result", int'(out_ch), 4500);

        // R6: unity, zero delay, constant
        cur_req = "R6";
        for (int i = 0; i < 5; i++) send(-1234, i, 16384, 0, 1);
        repeat (8) @(negedge clk);
        chk("R6", "pass-through", int'(out_ch), -1234);

        // R7: overshoot patterns and gain clamp
        cur_req = "R7";
        send(-8192, 1, 16384, 0, 0); send(8191, 2, 16384, 0, 0);
        send(8191, 3, 16384, 0, 0);  send(-8192, 4, 16384, 0, 0);
        repeat (8) @(negedge clk);
        chk("R7", "positive clamp", int'(out_ch), 8191);
        send(8191, 5, 16384, 0, 0);  send(-8192, 6, 16384, 0, 0);
        send(-8192, 7, 16384, 0, 0); send(8191, 8, 16384, 0, 0);
        repeat (8) @(negedge clk);
        chk("R7", "negative clamp", int'(out_ch), -8192);
        for (int i = 0; i < 4; i++) send(8191, i, 65535, 0, 0);
        repeat (8) @(negedge clk);
        chk("R7", "gain clamp", int'(out_ch), 8191);

        // R8: words change while a sample is in flight
        cur_req = "R8";
        send(2000, 9, 20000, 40, 3);
        send(-2000, 10, 13000, -90, 4);
        send(1500, 11, 16384, 110, 2);
        repeat (8) @(negedge clk);

        // R3: exact latency
        cur_req = "R3";
        send(777, 12, 16384, 0, 0);
        repeat (3) @(negedge clk);
        chk("R3", "out_valid after 4 edges", int'(out_valid), 0);
        @(negedge clk);
        chk("R3", "out_valid after 5 edges", int'(out_valid), 1);
        repeat (4) @(negedge clk);
        chk("R2", "final output count", out_n, sent_n - 3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule